// File: doc/BRIEF.md
# FIFO Read-Strobe Drain Controller

This block sits on the read side of a FIFO that uses strobe handshaking. It generates the read strobe, takes each word the FIFO presents into a single holding register, and passes the words to a downstream consumer over a valid/ready pair. The FIFO signals that a word sits on its outputs with a data-present flag. It signals that it can take another write with a room flag. The writer's strobe is also visible to the controller, which uses it to keep its own count of the words in the FIFO.

Three read policies are available, and an input selects one of them. Acknowledge mode holds the read strobe high until the FIFO lowers its data-present flag, so a strobe issued close to a boundary is never cut short. Guard mode holds back only the first read after the FIFO has been empty. That read waits for a window of at least GUARD_PS picoseconds, counted in clock cycles, from the moment data-present first rises. Half mode starts no read until the counted occupancy is above half the depth. In every mode a strobe stays high for at least MIN_HIGH cycles, and no strobe is issued while the holding register is occupied and the consumer is stalling.

Top module: `fifo_drain_ctrl`

## Requirements
- R1: Reset drives the read strobe low and clears the holding register's valid flag. It also re-arms first-read tracking, so the first read after reset in guard mode waits the full guard window.
- R2: The read strobe rises only in a cycle after data-present was sampled high. Between two strobes it stays low for at least one cycle.
- R3: The holding register loads the FIFO output word on the same clock edge that raises the read strobe. The consumer receives the words in the order they were written.
- R4: Acknowledge mode is mode code 0, and code 3 behaves the same way. While data-present is high the strobe stays high. It falls on the first edge that samples data-present low, once R5 is met.
- R5: Every strobe pulse is high for at least MIN_HIGH clock cycles.
- R6: Guard mode is mode code 1. GUARD_CYC is GUARD_PS divided by CLK_PERIOD_PS, rounded up. When data-present rises while the FIFO is empty, the read strobe rises GUARD_CYC+1 cycles after data-present rises. This happens again each time the FIFO drains to empty.
- R7: In guard mode, reads after the first one from empty are not delayed. The strobe rises one cycle after data-present rises again.
- R8: Half mode is mode code 2. A read starts only when the occupancy is above DEPTH/2. Occupancy counts one for each rising edge of the write strobe while the room flag is high, and loses one for each completed read strobe.
- R9: While the holding register is valid and ready is low, no new strobe is issued, and the presented word and its valid flag stay unchanged.
- R10: In guard and half modes a strobe is high for exactly MIN_HIGH cycles, whatever data-present does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Read policy: 0 acknowledge, 1 guard, 2 half, 3 acknowledge |
| fifo_has_data_i | input | 1 | FIFO data-present flag |
| fifo_has_room_i | input | 1 | FIFO room flag |
| fifo_wr_strobe_i | input | 1 | Writer's strobe, observed for occupancy |
| fifo_dout_i | input | DATA_W | FIFO output word |
| fifo_rd_strobe_o | output | 1 | Read strobe to the FIFO, registered |
| m_data_o | output | DATA_W | Captured word |
| m_valid_o | output | 1 | Captured word is valid |
| m_ready_i | input | 1 | Consumer accepts the word |

## Verification
The assertions check the rules that hold on every cycle:
- a strobe only follows data-present;
- in acknowledge mode the strobe is held while data-present is high;
- the minimum pulse width, and the exact width in the fixed-width modes;
- the guard wait on the first read after reset;
- that a stalled consumer blocks new reads and sees a stable word.

The bench scenarios show what needs a whole sequence:
- the exact guard latency each time the FIFO drains and refills;
- full-rate reads after the first one;
- the half-depth threshold, which depends on the counted occupancy;
- the order of captured words under backpressure and across a reset.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [1:0] {
    MODE_ACK   = 2'd0,
    MODE_GUARD = 2'd1,
    MODE_HALF  = 2'd2
  } drain_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_REST = 2'd2
  } strobe_st_e;
endpackage

// File: rtl/fdc_occupancy.sv
module fdc_occupancy #(
  parameter int DEPTH = 16,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_strobe_i,
  input  logic             room_i,
  input  logic             rd_done_i,
  output logic [OCC_W-1:0] occ_o,
  output logic             empty_o
);
  logic             strobe_q;
  logic [OCC_W-1:0] occ_q;
  logic             wr_hit;
  logic             rd_hit;

  // A write lands on the rising edge of the writer strobe when room exists
  assign wr_hit = wr_strobe_i && !strobe_q && room_i;
  assign rd_hit = rd_done_i && (occ_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      occ_q    <= '0;
    end else begin
      strobe_q <= wr_strobe_i;
      case ({wr_hit, rd_hit})
        2'b10: if (occ_q != OCC_W'(DEPTH)) occ_q <= occ_q + 1'b1;
        2'b01: occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign occ_o   = occ_q;
  assign empty_o = (occ_q == '0);
endmodule

// File: rtl/fdc_guard.sv
module fdc_guard #(
  parameter int GUARD_CYC = 8,
  localparam int GC_W = (GUARD_CYC < 1) ? 1 : $clog2(GUARD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic empty_i,
  input  logic has_data_i,
  input  logic issue_i,
  output logic ok_o
);
  logic            pend_q;
  logic [GC_W-1:0] cnt_q;

  // pend_q marks that the next read is the first one after empty
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (issue_i) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (empty_i) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q && has_data_i && (cnt_q != GC_W'(GUARD_CYC))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = !pend_q || (cnt_q == GC_W'(GUARD_CYC));
endmodule

// File: rtl/fdc_strobe.sv
module fdc_strobe import fdc_pkg::*; #(
  parameter int MIN_HIGH = 1,
  localparam int HW = $clog2(MIN_HIGH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic has_data_i,
  input  logic need_ack_i,
  output logic idle_o,
  output logic strobe_o,
  output logic done_o
);
  strobe_st_e    st_q;
  logic [HW-1:0] hi_q;
  logic          strobe_q;
  logic          release_now;

  assign release_now = (st_q == ST_HIGH) && (hi_q >= HW'(MIN_HIGH))
                       && (!need_ack_i || !has_data_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      hi_q     <= '0;
      strobe_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (go_i) begin
          st_q     <= ST_HIGH;
          strobe_q <= 1'b1;
          hi_q     <= HW'(1);
        end
        ST_HIGH: if (release_now) begin
          st_q     <= ST_REST;
          strobe_q <= 1'b0;
        end else if (hi_q != HW'(MIN_HIGH)) begin
          hi_q <= hi_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o   = (st_q == ST_IDLE);
  assign strobe_o = strobe_q;
  assign done_o   = release_now;
endmodule

// File: rtl/fdc_capture.sv
module fdc_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              slot_free_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) data_q <= din_i;
  end

  assign data_o      = data_q;
  assign valid_o     = valid_q;
  assign slot_free_o = !valid_q || ready_i;
endmodule

// File: rtl/fifo_drain_ctrl.sv
module fifo_drain_ctrl import fdc_pkg::*; #(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 16,
  parameter int MIN_HIGH      = 1,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int GUARD_PS      = 40000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode_i,
  input  logic              fifo_has_data_i,
  input  logic              fifo_has_room_i,
  input  logic              fifo_wr_strobe_i,
  input  logic [DATA_W-1:0] fifo_dout_i,
  output logic              fifo_rd_strobe_o,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_valid_o,
  input  logic              m_ready_i
);
  localparam int GUARD_CYC = (GUARD_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int OCC_W     = $clog2(DEPTH + 1);
  localparam int HALF_LVL  = DEPTH / 2;

  drain_mode_e      mode;
  logic [OCC_W-1:0] occ;
  logic             empty;
  logic             idle;
  logic             slot_free;
  logic             guard_ok;
  logic             mode_ok;
  logic             need_ack;
  logic             go;
  logic             rd_done;

  always_comb mode = drain_mode_e'(mode_i);

  always_comb begin
    case (mode)
      MODE_GUARD: begin mode_ok = guard_ok;                need_ack = 1'b0; end
      MODE_HALF:  begin mode_ok = (occ > OCC_W'(HALF_LVL)); need_ack = 1'b0; end
      default:    begin mode_ok = 1'b1;                    need_ack = 1'b1; end
    endcase
  end

  assign go = idle && fifo_has_data_i && slot_free && mode_ok;

  fdc_occupancy #(.DEPTH(DEPTH)) occ_i (
    .clk(clk), .rst(rst),
    .wr_strobe_i(fifo_wr_strobe_i), .room_i(fifo_has_room_i),
    .rd_done_i(rd_done), .occ_o(occ), .empty_o(empty)
  );

  fdc_guard #(.GUARD_CYC(GUARD_CYC)) guard_i (
    .clk(clk), .rst(rst), .empty_i(empty),
    .has_data_i(fifo_has_data_i), .issue_i(go), .ok_o(guard_ok)
  );

  fdc_strobe #(.MIN_HIGH(MIN_HIGH)) strobe_i (
    .clk(clk), .rst(rst), .go_i(go), .has_data_i(fifo_has_data_i),
    .need_ack_i(need_ack), .idle_o(idle), .strobe_o(fifo_rd_strobe_o),
    .done_o(rd_done)
  );

  fdc_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst(rst), .load_i(go), .din_i(fifo_dout_i),
    .ready_i(m_ready_i), .data_o(m_data_o), .valid_o(m_valid_o),
    .slot_free_o(slot_free)
  );
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker #(
  parameter int DATA_W    = 8,
  parameter int MIN_HIGH  = 1,
  parameter int GUARD_CYC = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode_i,
  input logic              has_data,
  input logic              rd,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data
);
  logic [7:0] hc_q;
  logic [7:0] orun_q;
  logic       seen_q;
  logic       rst_q;
  logic       fixed;
  logic       ack_mode;

  assign fixed    = (mode_i == 2'd1) || (mode_i == 2'd2);
  assign ack_mode = !fixed;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      hc_q   <= '0;
      orun_q <= '0;
      seen_q <= 1'b0;
    end else begin
      hc_q   <= rd ? ((hc_q == 8'hff) ? hc_q : hc_q + 8'd1) : 8'd0;
      orun_q <= has_data ? ((orun_q == 8'hff) ? orun_q : orun_q + 8'd1) : 8'd0;
      if (rd) seen_q <= 1'b1;
    end
  end

  // R1: outputs cleared on the first edge after reset was applied
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      a_r1_reset_clears: assert (!rd && !m_valid);
    end
  end

  a_r2_strobe_needs_data: assert property (@(posedge clk) disable iff (rst)
    $rose(rd) |-> $past(has_data));

  a_r4_ack_hold: assert property (@(posedge clk) disable iff (rst)
    (ack_mode && rd && has_data) |=> rd);

  a_r5_min_width: assert property (@(posedge clk) disable iff (rst)
    $fell(rd) |-> (int'(hc_q) >= MIN_HIGH));

  a_r6_guard_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd) && (mode_i == 2'd1) && !seen_q) |-> (int'(orun_q) >= GUARD_CYC));

  a_r9_no_issue_when_full: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready && !rd) |=> !rd);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r10_fixed_width: assert property (@(posedge clk) disable iff (rst)
    (fixed && rd && (int'(hc_q) >= MIN_HIGH - 1)) |=> !rd);
endmodule

bind fifo_drain_ctrl fdc_checker #(
  .DATA_W(DATA_W), .MIN_HIGH(MIN_HIGH), .GUARD_CYC(GUARD_CYC)
) chk_i (
  .clk(clk), .rst(rst), .mode_i(mode_i), .has_data(fifo_has_data_i),
  .rd(fifo_rd_strobe_o), .m_valid(m_valid_o), .m_ready(m_ready_i),
  .m_data(m_data_o)
);

// File: tb/fifo_drain_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_drain_ctrl_tb_top;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int MINH  = 2;
  localparam int CLKPS = 5000;
  localparam int GPS   = 40000;
  localparam int GC    = (GPS + CLKPS - 1) / CLKPS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic          has_data = 1'b0;
  logic          has_room = 1'b1;
  logic          wr = 1'b0;
  logic [DW-1:0] din_w = '0;
  logic [DW-1:0] fifo_dout = '0;
  logic          rd;
  logic [DW-1:0] m_data;
  logic          m_valid;
  logic          m_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  int drop_lat = 1;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fifo_drain_ctrl #(.DATA_W(DW), .DEPTH(DEPTH), .MIN_HIGH(MINH),
    .CLK_PERIOD_PS(CLKPS), .GUARD_PS(GPS)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode), .fifo_has_data_i(has_data),
    .fifo_has_room_i(has_room), .fifo_wr_strobe_i(wr), .fifo_dout_i(fifo_dout),
    .fifo_rd_strobe_o(rd), .m_data_o(m_data), .m_valid_o(m_valid),
    .m_ready_i(m_ready));

  // Behavioural strobe FIFO
  logic [DW-1:0] mem [DEPTH];
  int head, tail, n, gap, hi;
  bit si_p, so_p;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      head = 0; tail = 0; n = 0; gap = 0; hi = 0; si_p = 0; so_p = 0;
      has_data <= 1'b0; has_room <= 1'b1; fifo_dout <= '0;
    end else begin
      if (wr && !si_p && has_room) begin
        mem[tail] = din_w; tail = (tail + 1) % DEPTH; n++;
      end
      if (!rd && so_p) begin head = (head + 1) % DEPTH; n--; gap = 2; end
      if (rd) begin
        hi++;
        if (hi >= drop_lat) has_data <= 1'b0;
      end else begin
        hi = 0;
        if (gap > 0) begin gap--; has_data <= 1'b0; end
        else has_data <= (n > 0);
      end
      has_room  <= (n < DEPTH);
      fifo_dout <= mem[head];
      si_p = wr; so_p = rd;
    end
  end

  // Monitor, sampled on the falling edge
  logic [DW-1:0] rx [64];
  int gaps [64];
  int widths [64];
  int rxn, rises, last_or, hw, bad_ack;
  bit or_pn, rd_pn;
  always @(negedge clk) begin
    if (rst) begin
      rxn = 0; rises = 0; last_or = 0; hw = 0; bad_ack = 0;
    end else begin
      if (has_data && !or_pn) last_or = cyc;
      if (rd && !rd_pn) begin
        if (rises < 64) gaps[rises] = cyc - last_or;
        rises++; hw = 0;
      end
      if (rd) hw++;
      if (!rd && rd_pn) begin
        if (rises > 0 && rises <= 64) widths[rises-1] = hw;
        if (mode == 2'd0 && or_pn) bad_ack++;
      end
      if (m_valid && m_ready && rxn < 64) begin rx[rxn] = m_data; rxn++; end
    end
    or_pn = has_data; rd_pn = rd;
  end

  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] v);
    for (int w = 0; w < 200 && !has_room; w++) tick(1);
    din_w = v; wr = 1'b1; tick(1);
    wr = 1'b0; tick(1);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr = 1'b0; tick(4);
    rst = 1'b0; tick(2);
  endtask

  initial begin
    // R1: reset state
    tick(1);
    do_reset();
    check("R1 strobe after reset", int'(rd), 0);
    check("R1 valid after reset", int'(m_valid), 0);

    // R2 R3 R4: acknowledge mode with a slow flag drop
    mode = 2'd0; drop_lat = 4; m_ready = 1'b1;
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    tick(80);
    check("R3 ack count", rxn, 5);
    for (int i = 0; i < 5; i++) begin
      check("R3 ack order", int'(rx[i]), 'hA0 + i);
      check("R4 stretched width", widths[i], drop_lat + 1);
    end
    check("R4 fell while flag high", bad_ack, 0);
    check("R2 first read latency", gaps[0], 1);

    // R6 R7 R10: guard mode
    do_reset();
    mode = 2'd1; drop_lat = 1;
    for (int i = 0; i < 3; i++) push(8'h30 + 8'(i));
    tick(60);
    check("R6 guard latency", gaps[0], GC + 1);
    check("R7 second read", gaps[1], 1);
    check("R7 third read", gaps[2], 1);
    for (int i = 0; i < 3; i++) begin
      check("R10 fixed width", widths[i], MINH);
      check("R3 guard order", int'(rx[i]), 'h30 + i);
    end
    push(8'h55);
    tick(40);
    check("R6 rearmed after empty", gaps[3], GC + 1);
    check("R3 guard last word", int'(rx[3]), 'h55);

    // R8: half mode
    do_reset();
    mode = 2'd2;
    for (int i = 0; i < DEPTH/2; i++) push(8'h10 + 8'(i));
    tick(40);
    check("R8 no read at half", rises, 0);
    push(8'h10 + 8'(DEPTH/2));
    tick(40);
    check("R8 one read above half", rises, 1);
    check("R8 first word", int'(rx[0]), 'h10);
    push(8'h15); push(8'h16);
    tick(40);
    check("R8 reads back to half", rises, 3);
    check("R10 half width", widths[2], MINH);
    mode = 2'd0;
    tick(60);
    check("R8 drained count", rxn, 7);
    for (int i = 0; i < 7; i++) check("R3 half order", int'(rx[i]), 'h10 + i);

    // R9: backpressure
    do_reset();
    mode = 2'd3; m_ready = 1'b0;
    for (int i = 0; i < 3; i++) push(8'hC0 + 8'(i));
    tick(40);
    check("R9 single read while stalled", rises, 1);
    check("R9 valid held", int'(m_valid), 1);
    check("R9 word held", int'(m_data), 'hC0);
    m_ready = 1'b1;
    tick(40);
    check("R9 released count", rxn, 3);
    for (int i = 0; i < 3; i++) check("R9 order", int'(rx[i]), 'hC0 + i);
    check("R5 width mode 3", widths[0], MINH);

    // R1: reset in the middle of traffic
    m_ready = 1'b0;
    push(8'hE0); push(8'hE1);
    tick(20);
    check("R1 valid before reset", int'(m_valid), 1);
    rst = 1'b1; tick(2);
    rst = 1'b0; tick(1);
    check("R1 strobe after mid reset", int'(rd), 0);
    check("R1 valid after mid reset", int'(m_valid), 0);
    m_ready = 1'b1; mode = 2'd1;
    push(8'h77);
    tick(40);
    check("R1 guard rearmed", gaps[0], GC + 1);
    check("R1 word after reset", int'(rx[0]), 'h77);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule